// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch

This block produces the 9-bit address of the next microinstruction for a 512-word microcode store in a small microcoded processor. The store sits outside the block. It presents the word at the current address as plain inputs: an 8-bit next-address field, a 4-bit action code and a branch-sense bit. From these, the block picks the next address from one of four sources: the literal next field, an interrupt/fault priority-encoder vector, the opcode held in the instruction register, or the current address plus one when a conditional microbranch is not taken.

The block also owns three pieces of state tied to the start of an instruction: the instruction register, a saved copy of the program counter (trap PC), and a one-cycle strobe that tells the datapath to clear its memory data register. A halt action freezes the sequencer until reset. All interfaces are plain control pins with no handshake. A new microinstruction is taken on every clock edge, and the only stall is the halt.

Top module: `ucode_sequencer`

## Requirements
- R1: With any action code other than 0x2 (halt) or 0xB (branch), and a next field that is neither 0x00 nor 0xFF, the address after the clock edge has its low 8 bits equal to the next field.
- R2: With a next field of 0x00 and an action code other than 0x2 or 0xB, the low 8 bits of the next address come from `prio_vec`.
- R3: With a next field of 0xFF and an action code other than 0x2 or 0xB, the low 8 bits of the next address come from the instruction register.
- R4: For every loaded target (R1, R2, R3 and a taken branch), address bit 8 is 1 unless the instruction register currently holds 0xFF, in which case it is 0.
- R5: Action code 0xB is a conditional branch. When taken, it loads the literal next field (0x00 and 0xFF are not treated as dispatch codes). When not taken, it loads the current address plus one, modulo 512.
- R6: The branch condition is selected by instruction-register bits 3..1. The encodings are 0 eq, 1 eq, 2 lt, 3 le, 4 ltu, 5 leu, 6 eq, 7 ne. With `flags` = {Z,N,V,C} at bits 3..0: eq = Z, ne = !Z, lt = N^V, le = (N^V)|Z, ltu = C, leu = C|Z. A `br_sense` of 1 inverts the result.
- R7: Action code 0x7 (instruction start) loads the instruction register from `fetch_byte` and the trap PC from `pc_in`, and raises `mdr_clear` for exactly the following cycle. Address selection in that same cycle still uses the previous instruction-register value.
- R8: Action code 0x2 sets `halted`. While it is present or `halted` is set, the address holds its value, and the instruction register, trap PC and `mdr_clear` do not change or pulse. `halted` stays set until reset.
- R9: A low `rst_n` at a clock edge sets the address to 0x100, the instruction register and trap PC to 0, and `halted` and `mdr_clear` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| next_field | input | 8 | Next-address field of the current microinstruction |
| act_code | input | 4 | Action code of the current microinstruction |
| br_sense | input | 1 | Invert the branch condition when 1 |
| flags | input | 4 | Status flags {Z,N,V,C} |
| prio_vec | input | 8 | Interrupt/fault priority-encoder vector |
| fetch_byte | input | 8 | Opcode byte captured on instruction start |
| pc_in | input | 16 | Program counter captured on instruction start |
| uaddr | output | 9 | Current microaddress |
| ir_q | output | 8 | Instruction register |
| tpc_q | output | 16 | Saved trap PC |
| mdr_clear | output | 1 | One-cycle request to clear the data register |
| halted | output | 1 | Sequencer halted |

## Verification
A vector sequence takes the address through plain next fields, priority and opcode dispatch, and branches under all four condition families (eq, ne, le, ltu/leu), with both sense values. This separates a wrong condition encoding from a wrong inversion. The instruction register is changed several times mid-sequence, including to 0xFF. This shows that the ninth bit follows the register and not the next field, and that an instruction-start cycle still dispatches on the old opcode. A fall-through from 0x1FF exposes a missing 9-bit wrap. A halt followed by normal actions and an instruction start shows that nothing moves until reset.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam logic [3:0] ACT_HALT   = 4'h2;
  localparam logic [3:0] ACT_START  = 4'h7;
  localparam logic [3:0] ACT_BRANCH = 4'hB;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [2:0] {
    CND_EQ0 = 3'd0, CND_EQ1 = 3'd1, CND_LT  = 3'd2, CND_LE = 3'd3,
    CND_LTU = 3'd4, CND_LEU = 3'd5, CND_EQ6 = 3'd6, CND_NE = 3'd7
  } cond_e;
endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       sense,
  input  flags_t     fl,
  output logic       take
);
  logic raw;
  always_comb begin
    unique case (cond_e'(sel))
      CND_LT:  raw = fl.n ^ fl.v;
      CND_LE:  raw = (fl.n ^ fl.v) | fl.z;
      CND_LTU: raw = fl.c;
      CND_LEU: raw = fl.c | fl.z;
      CND_NE:  raw = ~fl.z;
      default: raw = fl.z;
    endcase
    take = raw ^ sense;
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux #(
  parameter int NEXT_W = 8,
  localparam int ADDR_W = NEXT_W + 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [NEXT_W-1:0] next_field,
  input  logic [NEXT_W-1:0] ir,
  input  logic [NEXT_W-1:0] prio_vec,
  input  logic              is_branch,
  input  logic              take,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam logic [NEXT_W-1:0] CODE_PRIO = '0;
  localparam logic [NEXT_W-1:0] CODE_OPC  = '1;

  logic              page;
  logic [NEXT_W-1:0] low;

  always_comb begin
    page = ~(ir == CODE_OPC);
    if (is_branch)                     low = next_field;
    else if (next_field == CODE_PRIO)  low = prio_vec;
    else if (next_field == CODE_OPC)   low = ir;
    else                               low = next_field;

    if (is_branch && !take) nxt_addr = cur_addr + ADDR_W'(1);
    else                    nxt_addr = {page, low};
  end
endmodule

// File: rtl/useq_start_regs.sv
module useq_start_regs #(
  parameter int IR_W = 8,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IR_W-1:0] fetch_byte,
  input  logic [PC_W-1:0] pc_in,
  output logic [IR_W-1:0] ir_q,
  output logic [PC_W-1:0] tpc_q,
  output logic            mdr_clear
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q      <= '0;
      tpc_q     <= '0;
      mdr_clear <= 1'b0;
    end else begin
      mdr_clear <= load;
      if (load) begin
        ir_q  <= fetch_byte;
        tpc_q <= pc_in;
      end
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int NEXT_W = 8,
  parameter int PC_W   = 16,
  parameter int RESET_ADDR = 'h100,
  localparam int ADDR_W = NEXT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT_W-1:0] next_field,
  input  logic [3:0]        act_code,
  input  logic              br_sense,
  input  logic [3:0]        flags,
  input  logic [NEXT_W-1:0] prio_vec,
  input  logic [NEXT_W-1:0] fetch_byte,
  input  logic [PC_W-1:0]   pc_in,
  output logic [ADDR_W-1:0] uaddr,
  output logic [NEXT_W-1:0] ir_q,
  output logic [PC_W-1:0]   tpc_q,
  output logic              mdr_clear,
  output logic              halted
);
  logic              do_halt, is_branch, take, run;
  logic [ADDR_W-1:0] nxt_addr;

  assign do_halt   = (act_code == ACT_HALT);
  assign is_branch = (act_code == ACT_BRANCH);
  assign run       = ~halted & ~do_halt;

  useq_cond_eval u_cond (
    .sel   (ir_q[3:1]),
    .sense (br_sense),
    .fl    (flags_t'(flags)),
    .take  (take)
  );

  useq_addr_mux #(.NEXT_W(NEXT_W)) u_mux (
    .cur_addr   (uaddr),
    .next_field (next_field),
    .ir         (ir_q),
    .prio_vec   (prio_vec),
    .is_branch  (is_branch),
    .take       (take),
    .nxt_addr   (nxt_addr)
  );

  useq_start_regs #(.IR_W(NEXT_W), .PC_W(PC_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (run && (act_code == ACT_START)),
    .fetch_byte (fetch_byte),
    .pc_in      (pc_in),
    .ir_q       (ir_q),
    .tpc_q      (tpc_q),
    .mdr_clear  (mdr_clear)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uaddr  <= ADDR_W'(RESET_ADDR);
      halted <= 1'b0;
    end else begin
      if (do_halt) halted <= 1'b1;
      if (run)     uaddr  <= nxt_addr;
    end
  end
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int NEXT_W = 8,
  parameter int PC_W   = 16,
  localparam int ADDR_W = NEXT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEXT_W-1:0] next_field,
  input logic [3:0]        act_code,
  input logic [NEXT_W-1:0] prio_vec,
  input logic [PC_W-1:0]   pc_in,
  input logic [ADDR_W-1:0] uaddr,
  input logic [PC_W-1:0]   tpc_q,
  input logic              mdr_clear,
  input logic              halted
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(uaddr) && halted); // R8
  AST_START_TPC: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 4'h7 && !halted) |=> tpc_q == $past(pc_in)); // R7
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_clear && $past(rst_n)) |-> $past(act_code) == 4'h7 && !$past(halted)); // R7
  AST_BRANCH_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 4'hB && !halted) |=>
      (uaddr == $past(uaddr) + ADDR_W'(1)) || (uaddr[NEXT_W-1:0] == $past(next_field))); // R5
  AST_PRIO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (next_field == '0 && act_code != 4'hB && act_code != 4'h2 && !halted) |=>
      uaddr[NEXT_W-1:0] == $past(prio_vec)); // R2
endmodule

bind ucode_sequencer useq_checker #(.NEXT_W(NEXT_W), .PC_W(PC_W)) u_useq_chk (
  .clk(clk), .rst_n(rst_n), .next_field(next_field), .act_code(act_code),
  .prio_vec(prio_vec), .pc_in(pc_in), .uaddr(uaddr), .tpc_q(tpc_q),
  .mdr_clear(mdr_clear), .halted(halted)
);

// File: tb/test_ucode_sequencer.sv
module test_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  next_field, prio_vec, fetch_byte, ir_q;
  logic [3:0]  act_code, flags;
  logic        br_sense, mdr_clear, halted;
  logic [15:0] pc_in, tpc_q;
  logic [8:0]  uaddr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ucode_sequencer i_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .next_field(next_field), .act_code(act_code),
    .br_sense(br_sense), .flags(flags), .prio_vec(prio_vec),
    .fetch_byte(fetch_byte), .pc_in(pc_in), .uaddr(uaddr), .ir_q(ir_q),
    .tpc_q(tpc_q), .mdr_clear(mdr_clear), .halted(halted)
  );

  // {act[41:38], next[37:30], sense[29], flags{Z,N,V,C}[28:25], prio[24:17], fetch[16:9], exp_addr[8:0]}
  localparam logic [41:0] VEC [0:27] = '{
    {4'h0, 8'h20, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h120},
    {4'h0, 8'h00, 1'b0, 4'b0000, 8'h45, 8'h00, 9'h145},
    {4'h7, 8'h50, 1'b0, 4'b0000, 8'h00, 8'h36, 9'h150},
    {4'h0, 8'hFF, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h136},
    {4'hB, 8'h80, 1'b0, 4'b1000, 8'h00, 8'h00, 9'h180},
    {4'hB, 8'h10, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h181},
    {4'hB, 8'h10, 1'b1, 4'b0000, 8'h00, 8'h00, 9'h110},
    {4'hB, 8'h22, 1'b0, 4'b0100, 8'h00, 8'h00, 9'h122},
    {4'hB, 8'h30, 1'b0, 4'b0110, 8'h00, 8'h00, 9'h123},
    {4'h7, 8'h40, 1'b0, 4'b0000, 8'h00, 8'h38, 9'h140},
    {4'hB, 8'h60, 1'b0, 4'b0001, 8'h00, 8'h00, 9'h160},
    {4'hB, 8'h60, 1'b0, 4'b1000, 8'h00, 8'h00, 9'h161},
    {4'h7, 8'h70, 1'b0, 4'b0000, 8'h00, 8'h0E, 9'h170},
    {4'hB, 8'h05, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h105},
    {4'hB, 8'h05, 1'b1, 4'b0000, 8'h00, 8'h00, 9'h106},
    {4'h7, 8'h08, 1'b0, 4'b0000, 8'h00, 8'hFF, 9'h108},
    {4'h0, 8'hFF, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h0FF},
    {4'h0, 8'h33, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h033},
    {4'h0, 8'h00, 1'b0, 4'b0000, 8'h9A, 8'h00, 9'h09A},
    {4'hB, 8'h44, 1'b0, 4'b1000, 8'h00, 8'h00, 9'h09B},
    {4'h7, 8'h02, 1'b0, 4'b0000, 8'h00, 8'h0A, 9'h002},
    {4'hB, 8'h77, 1'b0, 4'b1000, 8'h00, 8'h00, 9'h177},
    {4'h7, 8'h01, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h101},
    {4'hB, 8'h0C, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h102},
    {4'hB, 8'h0C, 1'b1, 4'b0000, 8'h00, 8'h00, 9'h10C},
    {4'h0, 8'h00, 1'b0, 4'b0000, 8'hFF, 8'h00, 9'h1FF},
    {4'hB, 8'h0C, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h000},
    {4'h6, 8'h55, 1'b0, 4'b0000, 8'h00, 8'h00, 9'h155}
  };

  function automatic string tag_of(input logic [3:0] a, input logic [7:0] n);
    if (a == 4'hB)      return "R5/R6";
    else if (a == 4'h7) return "R7/R4";
    else if (n == 8'hFF) return "R3/R4";
    else if (n == 8'h00) return "R2/R4";
    else                return "R1/R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] a, input logic [7:0] n, input logic s,
                       input logic [3:0] f, input logic [7:0] p, input logic [7:0] fb,
                       input logic [15:0] pc);
    act_code = a; next_field = n; br_sense = s; flags = f;
    prio_vec = p; fetch_byte = fb; pc_in = pc;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(4'h0, 8'h00, 1'b0, 4'h0, 8'h00, 8'h00, 16'h0000);
    repeat (3) @(negedge clk);
    check("R9 addr", 32'(uaddr), 32'h100);
    check("R9 ir", 32'(ir_q), 32'h0);
    check("R9 halted", 32'(halted), 32'h0);
    check("R9 clear", 32'(mdr_clear), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 28; i++) begin
      logic [41:0] v;
      v = VEC[i];
      drive(v[41:38], v[37:30], v[29], v[28:25], v[24:17], v[16:9], 16'hA000 + 16'(i));
      @(negedge clk);
      check(tag_of(v[41:38], v[37:30]), 32'(uaddr), 32'(v[8:0]));
      if (v[41:38] == 4'h7) begin
        check("R7 ir", 32'(ir_q), 32'(v[16:9]));
        check("R7 tpc", 32'(tpc_q), 32'hA000 + 32'(i));
        check("R7 clear", 32'(mdr_clear), 32'h1);
      end else begin
        check("R7 clear idle", 32'(mdr_clear), 32'h0);
      end
    end

    // R8: halt freezes everything
    drive(4'h2, 8'h40, 1'b0, 4'h0, 8'h00, 8'h00, 16'h1111);
    @(negedge clk);
    check("R8 addr hold", 32'(uaddr), 32'h155);
    check("R8 halted", 32'(halted), 32'h1);
    drive(4'h0, 8'h20, 1'b0, 4'h0, 8'h00, 8'h00, 16'h2222);
    @(negedge clk);
    check("R8 sticky addr", 32'(uaddr), 32'h155);
    check("R8 sticky flag", 32'(halted), 32'h1);
    drive(4'h7, 8'h30, 1'b0, 4'h0, 8'h00, 8'h99, 16'h3333);
    @(negedge clk);
    check("R8 start ignored ir", 32'(ir_q), 32'h00);
    check("R8 start ignored tpc", 32'(tpc_q), 32'hA016);
    check("R8 start ignored clear", 32'(mdr_clear), 32'h0);
    check("R8 start ignored addr", 32'(uaddr), 32'h155);

    // R9: reset out of halt
    rst_n = 1'b0;
    drive(4'h0, 8'h00, 1'b0, 4'h0, 8'h00, 8'h00, 16'h0000);
    @(negedge clk);
    check("R9 addr after halt", 32'(uaddr), 32'h100);
    check("R9 halted cleared", 32'(halted), 32'h0);
    check("R9 tpc cleared", 32'(tpc_q), 32'h0);
    rst_n = 1'b1;
    drive(4'h0, 8'h21, 1'b0, 4'h0, 8'h00, 8'h00, 16'h0000);
    @(negedge clk);
    check("R1 resumes", 32'(uaddr), 32'h121);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule